// File: doc/BRIEF.md
# Serial NOR Flash Host Controller

This block is the host side of a single-lane SPI link to a serial NOR flash. A client hands it one request at a time over a valid/ready handshake: an operation (read data, page program, 4 KiB sector erase or read status), a 24-bit flash address and a byte count. The controller builds each flash frame itself. It sends the command byte, then the address, then the data phase. It drives chip select around whole frames and generates the serial clock by dividing the system clock.

Program data is pulled from the client one byte at a time through a write handshake. Read data and the status byte go back through a read handshake that can stall the link. Before a program or erase, the controller sends a separate write-enable frame. Afterwards it keeps reading the status register until the device reports that it is idle. Only then does it signal completion. Requests that break the page or length rules are refused without touching the bus. Every request ends with a one-cycle done pulse, and an error flag is raised in that same cycle when the request was refused.

Top module: `spi_flash_ctrl`

## Requirements
- R1: Every frame starts with the command byte. For read, program and erase the 24-bit address follows, high byte first. Every byte goes out most significant bit first.
- R2: The serial clock idles low (SPI mode 0) and each high phase lasts CLK_DIV/2 system clocks. `sf_mosi` changes only when the clock falls, and `sf_miso` is captured when the clock rises.
- R3: `sf_cs_n` goes high only after a whole number of bytes has been clocked, and the serial clock is never high while `sf_cs_n` is high.
- R4: The command byte depends on `req_op`. Code 0 is read (03h), code 1 is page program (02h), code 2 is sector erase (20h) and code 3 is read status (05h).
- R5: Each program or erase is preceded by a one-byte 06h frame of its own, with `sf_cs_n` going high between the two frames.
- R6: After a program or erase frame, the controller sends one-byte-plus-reply 05h frames until bit 0 of the reply is 0, and only then finishes the request. No other command is sent while the device reports busy.
- R7: The controller refuses a program with a count above PAGE_BYTES (256), and a read or program with a count of 0. A refused request drives no frame and ends with `done` and `err` both high.
- R8: Between frames, `sf_cs_n` stays high for at least CS_GAP system clocks.
- R9: `done` is high for exactly one cycle per request, `err` is high only together with `done`, and `req_ready` is high only while the controller is idle.
- R10: A program takes exactly `req_len` bytes through `wr_valid`/`wr_ready`. A read returns exactly `req_len` bytes through `rd_valid`/`rd_ready`, in address order. Each read byte is held stable until it is accepted.
- R11: A read-status request returns the single reply byte of one 05h frame on the read handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and accepting |
| req_op | input | 2 | Operation code (0 read, 1 program, 2 erase, 3 status) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Data byte count |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Controller takes a program byte |
| wr_data | input | 8 | Program byte |
| rd_valid | output | 1 | Read or status byte available |
| rd_ready | input | 1 | Client accepts the read byte |
| rd_data | output | 8 | Read or status byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with done |
| sf_sck | output | 1 | Serial clock to flash |
| sf_cs_n | output | 1 | Active-low chip select |
| sf_mosi | output | 1 | Serial data to flash |
| sf_miso | input | 1 | Serial data from flash |

## Verification
The bench connects a behavioural flash model that decodes frames bit by bit. The model keeps a write-enable latch and stays busy for a randomly chosen number of status reads. A controller that skipped write enable, polled too few times or sent commands while busy would be counted as a protocol violation, or would finish with the wrong number of polls. Page programs of exactly 256 bytes and refused counts of 257 and 0 probe the length limit: an off-by-one would either reject a legal page or start a frame for an illegal one. Read data is returned under random backpressure and compared with a reference memory. Clock high width, data stability during the high phase, byte-aligned chip-select release and the chip-select gap are measured on every frame.

// File: rtl/spif_pkg.sv
package spif_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_STAT  = 2'd3
    } spif_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_WAIT,
        S_LOAD,
        S_PUSH,
        S_GAP,
        S_FIN
    } spif_st_e;

    typedef enum logic [1:0] {
        F_WEN,
        F_MAIN,
        F_POLL
    } spif_frame_e;

    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_ERASE = 8'h20;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_WEN   = 8'h06;

    function automatic logic [7:0] opcode_of(spif_op_e op);
        case (op)
            OP_READ:  return CMD_READ;
            OP_PROG:  return CMD_PROG;
            OP_ERASE: return CMD_ERASE;
            default:  return CMD_RDSR;
        endcase
    endfunction

endpackage

// File: rtl/spif_clkdiv.sv
module spif_clkdiv #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF - 1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spif_byte_engine.sv
module spif_byte_engine #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       xfer_done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi
);
    typedef struct packed {
        logic       busy;
        logic       sck;
        logic [2:0] bitn;
        logic [7:0] tx;
        logic [7:0] rx;
    } eng_s;

    eng_s q, n;
    logic tick;

    spif_clkdiv #(.HALF(HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.busy),
        .tick (tick)
    );

    always_comb begin
        n         = q;
        xfer_done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                n.busy = 1'b1;
                n.sck  = 1'b0;
                n.bitn = 3'd0;
                n.tx   = tx_byte;
            end
        end else if (tick) begin
            if (!q.sck) begin
                n.sck = 1'b1;
                n.rx  = {q.rx[6:0], miso};
            end else begin
                n.sck = 1'b0;
                if (q.bitn == 3'd7) begin
                    n.busy    = 1'b0;
                    xfer_done = 1'b1;
                end else begin
                    n.bitn = q.bitn + 3'd1;
                    n.tx   = {q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy    = q.busy;
    assign rx_byte = q.rx;
    assign sck     = q.sck;
    assign mosi    = q.tx[7];

    // R2: outgoing bit moves only on a falling clock inside a byte
    assert_shift_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy) && !$fell(q.sck)) |-> $stable(q.tx));

    // R2: incoming bit captured only on a rising clock inside a byte
    assert_sample_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy) && !$rose(q.sck)) |-> $stable(q.rx));

    // R2: clock rests low outside a byte
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.sck);

endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
    import spif_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int CS_GAP     = 3,
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             err,
    output logic             sf_sck,
    output logic             sf_cs_n,
    output logic             sf_mosi,
    input  logic             sf_miso
);
    localparam int HALF  = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
    localparam int GAP   = (CS_GAP < 1) ? 1 : CS_GAP;
    localparam int GAP_W = (GAP > 1) ? $clog2(GAP) : 1;

    typedef struct packed {
        spif_st_e         st;
        spif_frame_e      frame;
        spif_op_e         op;
        logic [23:0]      addr;
        logic [LEN_W-1:0] rem;
        logic [1:0]       idx;
        logic             dph;
        logic [7:0]       tx;
        logic             cs_n;
        logic [7:0]       rdat;
        logic             rdv;
        logic             done;
        logic             err;
        logic             rej;
        logic             wip;
        logic [GAP_W-1:0] gap;
    } ctl_s;

    ctl_s q, n;

    logic       eng_start, eng_busy, eng_done;
    logic [7:0] eng_rx;
    logic       close;
    logic [1:0] hdr_last;
    logic       has_data;
    logic       bad_req;
    spif_op_e   in_op;

    spif_byte_engine #(.HALF(HALF)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .tx_byte  (q.tx),
        .miso     (sf_miso),
        .busy     (eng_busy),
        .xfer_done(eng_done),
        .rx_byte  (eng_rx),
        .sck      (sf_sck),
        .mosi     (sf_mosi)
    );

    function automatic logic [7:0] addr_byte(logic [23:0] a, logic [1:0] i);
        case (i)
            2'd1:    return a[23:16];
            2'd2:    return a[15:8];
            default: return a[7:0];
        endcase
    endfunction

    always_comb begin
        in_op   = spif_op_e'(req_op);
        bad_req = ((in_op == OP_READ || in_op == OP_PROG) && req_len == '0) ||
                  (in_op == OP_PROG && req_len > LEN_W'(PAGE_BYTES));

        hdr_last = 2'd0;
        has_data = 1'b0;
        case (q.frame)
            F_WEN:  begin hdr_last = 2'd0; has_data = 1'b0; end
            F_POLL: begin hdr_last = 2'd0; has_data = 1'b1; end
            default: begin
                hdr_last = (q.op == OP_STAT) ? 2'd0 : 2'd3;
                has_data = (q.op != OP_ERASE);
            end
        endcase

        n         = q;
        n.done    = 1'b0;
        n.err     = 1'b0;
        eng_start = 1'b0;
        close     = 1'b0;
        req_ready = (q.st == S_IDLE);
        wr_ready  = (q.st == S_LOAD);

        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    n.op   = in_op;
                    n.addr = req_addr;
                    n.rem  = (in_op == OP_STAT) ? LEN_W'(1) : req_len;
                    n.rej  = bad_req;
                    n.idx  = 2'd0;
                    n.dph  = 1'b0;
                    if (bad_req) begin
                        n.st = S_FIN;
                    end else if (in_op == OP_PROG || in_op == OP_ERASE) begin
                        n.frame = F_WEN;
                        n.tx    = CMD_WEN;
                        n.st    = S_SEND;
                    end else begin
                        n.frame = F_MAIN;
                        n.tx    = opcode_of(in_op);
                        n.st    = S_SEND;
                    end
                end
            end
            S_SEND: begin
                eng_start = 1'b1;
                n.cs_n    = 1'b0;
                n.st      = S_WAIT;
            end
            S_WAIT: begin
                if (eng_done) begin
                    if (!q.dph) begin
                        if (q.idx != hdr_last) begin
                            n.idx = q.idx + 2'd1;
                            n.tx  = addr_byte(q.addr, q.idx + 2'd1);
                            n.st  = S_SEND;
                        end else if (has_data) begin
                            n.dph = 1'b1;
                            if (q.frame == F_MAIN && q.op == OP_PROG) begin
                                n.st = S_LOAD;
                            end else begin
                                n.tx = 8'h00;
                                n.st = S_SEND;
                            end
                        end else begin
                            close = 1'b1;
                        end
                    end else if (q.frame == F_POLL) begin
                        n.wip = eng_rx[0];
                        close = 1'b1;
                    end else if (q.op == OP_PROG) begin
                        n.rem = q.rem - LEN_W'(1);
                        if (q.rem == LEN_W'(1)) close = 1'b1;
                        else                    n.st  = S_LOAD;
                    end else begin
                        n.rdat = eng_rx;
                        n.rdv  = 1'b1;
                        n.rem  = q.rem - LEN_W'(1);
                        n.st   = S_PUSH;
                    end
                end
            end
            S_LOAD: begin
                if (wr_valid) begin
                    n.tx = wr_data;
                    n.st = S_SEND;
                end
            end
            S_PUSH: begin
                if (rd_ready) begin
                    n.rdv = 1'b0;
                    if (q.rem == '0) begin
                        close = 1'b1;
                    end else begin
                        n.tx = 8'h00;
                        n.st = S_SEND;
                    end
                end
            end
            S_GAP: begin
                if (q.gap == GAP_W'(GAP - 1)) begin
                    n.gap = '0;
                    n.idx = 2'd0;
                    n.dph = 1'b0;
                    case (q.frame)
                        F_WEN: begin
                            n.frame = F_MAIN;
                            n.tx    = opcode_of(q.op);
                            n.st    = S_SEND;
                        end
                        F_MAIN: begin
                            if (q.op == OP_PROG || q.op == OP_ERASE) begin
                                n.frame = F_POLL;
                                n.tx    = CMD_RDSR;
                                n.st    = S_SEND;
                            end else begin
                                n.st = S_FIN;
                            end
                        end
                        default: begin
                            if (q.wip) begin
                                n.tx = CMD_RDSR;
                                n.st = S_SEND;
                            end else begin
                                n.st = S_FIN;
                            end
                        end
                    endcase
                end else begin
                    n.gap = q.gap + GAP_W'(1);
                end
            end
            S_FIN: begin
                n.done = 1'b1;
                n.err  = q.rej;
                n.st   = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase

        if (close) begin
            n.cs_n = 1'b1;
            n.gap  = '0;
            n.st   = S_GAP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.frame <= F_MAIN;
            q.op    <= OP_READ;
            q.cs_n  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign rd_valid = q.rdv;
    assign rd_data  = q.rdat;
    assign done     = q.done;
    assign err      = q.err;
    assign sf_cs_n  = q.cs_n;

    // R3: chip select released only between bytes, with the clock low
    assert_cs_release_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sf_cs_n) |-> (!eng_busy && !sf_sck));

    // R3: no clock activity while deselected
    assert_no_sck_when_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sf_cs_n |-> !sf_sck);

    // R6: only status frames are issued while the device reported busy
    assert_busy_only_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SEND && q.frame != F_POLL) |-> !q.wip);

    // R7: a program data phase never exceeds one page
    assert_page_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op == OP_PROG && q.frame == F_MAIN && q.dph && q.st != S_IDLE)
            |-> (q.rem <= LEN_W'(PAGE_BYTES)));

    // R9: done is a single-cycle pulse and err only accompanies it
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R10: a read byte is held until taken
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: tb/spi_flash_ctrl_test.sv
module spi_flash_ctrl_test;
    localparam int CLK_DIV = 4;
    localparam int CS_GAP  = 3;
    localparam int LEN_W   = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [7:0] wr_data = '0;
    logic rd_valid;
    logic rd_ready = 1'b0;
    logic [7:0] rd_data;
    logic done, err;
    logic sf_sck, sf_cs_n, sf_mosi, sf_miso;

    always #2.5 clk = ~clk;

    spi_flash_ctrl #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .PAGE_BYTES(256), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .err(err), .sf_sck(sf_sck), .sf_cs_n(sf_cs_n),
        .sf_mosi(sf_mosi), .sf_miso(sf_miso)
    );

    // ---------------- flash model and bus monitor (one process) ----------------
    logic [7:0]  fm [0:4095];
    logic [7:0]  m_pbuf [0:299];
    logic [7:0]  m_in, m_out, m_opc;
    logic [23:0] m_addr;
    logic        m_init = 1'b0, m_wel = 1'b0, miso_r = 1'b1;
    logic        pcs = 1'b1, psck = 1'b0, pmosi = 1'b0;
    int m_bit = 0, m_nb = 0, m_np = 0, m_busy_left = 0, m_busy_k = 0;
    int m_polls = 0, m_wen_frames = 0, m_proto = 0, m_misalign = 0, m_cs_falls = 0;
    int m_gap_bad = 0, m_sck_bad = 0, m_mosi_bad = 0, cs_hi = 0, sck_hi = 0;
    logic [7:0]  m_last_opc = 8'h00;
    logic [23:0] m_last_addr = '0;

    assign sf_miso = miso_r;

    always @(negedge clk) begin
        if (!m_init) begin
            for (int i = 0; i < 4096; i++) fm[i] = 8'hFF;
            m_init = 1'b1;
        end
        if (sf_cs_n && sf_sck) m_sck_bad++;
        if (sf_sck && psck && sf_mosi != pmosi) m_mosi_bad++;
        if (sf_sck) sck_hi++;
        else begin
            if (sck_hi > 0 && sck_hi != CLK_DIV / 2) m_sck_bad++;
            sck_hi = 0;
        end
        if (pcs && !sf_cs_n) begin
            if (cs_hi < CS_GAP) m_gap_bad++;
            m_bit = 0; m_nb = 0; m_np = 0; m_cs_falls++;
        end
        if (sf_cs_n) cs_hi++; else cs_hi = 0;
        if (!sf_cs_n && sf_sck && !psck) begin
            m_in = {m_in[6:0], sf_mosi};
            m_bit++;
            if (m_bit == 8) begin
                m_bit = 0;
                if (m_nb == 0) begin
                    m_opc = m_in;
                    if (m_busy_left > 0 && m_in != 8'h05) m_proto++;
                end else if (m_nb <= 3 && m_opc != 8'h05 && m_opc != 8'h06) begin
                    m_addr = {m_addr[15:0], m_in};
                end else if (m_opc == 8'h02 && m_np < 300) begin
                    m_pbuf[m_np] = m_in;
                    m_np++;
                end
                m_nb++;
            end
        end
        if (!sf_cs_n && !sf_sck && psck) begin
            if (m_bit == 0) begin
                m_out = 8'hA5;
                if (m_opc == 8'h05 && m_nb == 1) begin
                    m_out = {6'd0, m_wel, (m_busy_left > 0)};
                    if (m_busy_left > 0) m_busy_left--;
                    m_polls++;
                end else if (m_opc == 8'h03 && m_nb >= 4) begin
                    m_out = fm[12'(m_addr + 24'(m_nb - 4))];
                end
            end else begin
                m_out = {m_out[6:0], 1'b0};
            end
            miso_r = m_out[7];
        end
        if (!pcs && sf_cs_n) begin
            if (m_bit != 0) m_misalign++;
            m_last_opc = m_opc;
            if (m_opc == 8'h06) begin
                if (m_nb != 1) m_proto++;
                m_wel = 1'b1;
                m_wen_frames++;
            end else if (m_opc == 8'h02 || m_opc == 8'h20) begin
                m_last_addr = m_addr;
                if (!m_wel) m_proto++;
                if (m_opc == 8'h02) begin
                    if (m_np > 256) m_proto++;
                    for (int i = 0; i < m_np && i < 256; i++)
                        fm[12'(m_addr + 24'(i))] = fm[12'(m_addr + 24'(i))] & m_pbuf[i];
                end else begin
                    for (int i = 0; i < 4096; i++) fm[i] = 8'hFF;
                end
                m_wel = 1'b0;
                m_busy_left = m_busy_k;
            end else if (m_opc == 8'h03) begin
                m_last_addr = m_addr;
            end
        end
        pcs = sf_cs_n; psck = sf_sck; pmosi = sf_mosi;
    end

    // ---------------- bench bookkeeping ----------------
    int n_tests = 0, n_fail = 0;
    bit hung = 1'b0;
    logic [7:0] ref_mem [0:4095];
    logic [7:0] wbuf [0:299];
    logic [7:0] rbuf [0:299];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_req(input int op, input int addr, input int len, input int kbusy,
                           output bit got_err, output int nrd, output int nwr, output bit pulse_ok);
        int wlim, cyc;
        wlim = (op == 1) ? len : 0;
        nrd = 0; nwr = 0; got_err = 1'b0; cyc = 0;
        m_busy_k = kbusy;
        @(negedge clk);
        req_op = 2'(op); req_addr = 24'(addr); req_len = LEN_W'(len); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (done) begin got_err = err; break; end
            wr_valid = (nwr < wlim);
            wr_data  = (nwr < 300) ? wbuf[nwr] : 8'h00;
            if (wr_ready && wr_valid) nwr++;
            rd_ready = ($urandom % 4) != 0;
            if (rd_valid && rd_ready) begin
                if (nrd < 300) rbuf[nrd] = rd_data;
                nrd++;
            end
            cyc++;
            if (cyc > 40000) begin hung = 1'b1; break; end
            @(negedge clk);
        end
        wr_valid = 1'b0; rd_ready = 1'b0;
        @(negedge clk);
        pulse_ok = !done && req_ready;
    endtask

    task automatic do_read(input int addr, input int len);
        bit e, p; int nr, nw, bad;
        run_req(0, addr, len, 0, e, nr, nw, p);
        chk(!e, "R9 read err flag", int'(e), 0);
        chk(nr == len, "R10 read byte count", nr, len);
        bad = 0;
        for (int i = 0; i < nr && i < len; i++)
            if (rbuf[i] !== ref_mem[12'(addr + i)]) bad++;
        chk(bad == 0, "R10 read data mismatches", bad, 0);
        chk(m_last_opc == 8'h03, "R4 read opcode", int'(m_last_opc), 3);
        chk(m_last_addr == 24'(addr), "R1 read address", int'(m_last_addr), addr);
        chk(p, "R9 single done pulse", int'(p), 1);
    endtask

    task automatic do_prog(input int addr, input int len, input int k);
        bit e, p; int nr, nw, polls0, wen0;
        for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
        polls0 = m_polls; wen0 = m_wen_frames;
        run_req(1, addr, len, k, e, nr, nw, p);
        chk(!e, "R9 program err flag", int'(e), 0);
        chk(nw == len, "R10 program bytes taken", nw, len);
        chk(m_wen_frames == wen0 + 1, "R5 write enable frames", m_wen_frames - wen0, 1);
        chk(m_polls - polls0 == k + 1, "R6 status polls after program", m_polls - polls0, k + 1);
        chk(m_last_opc == 8'h05, "R6 last frame is status", int'(m_last_opc), 5);
        chk(m_last_addr == 24'(addr), "R1 program address", int'(m_last_addr), addr);
        chk(p, "R9 single done pulse", int'(p), 1);
        for (int i = 0; i < len; i++)
            ref_mem[12'(addr + i)] = ref_mem[12'(addr + i)] & wbuf[i];
    endtask

    task automatic do_erase(input int addr, input int k);
        bit e, p; int nr, nw, polls0, wen0;
        polls0 = m_polls; wen0 = m_wen_frames;
        run_req(2, addr, 0, k, e, nr, nw, p);
        chk(!e, "R9 erase err flag", int'(e), 0);
        chk(m_wen_frames == wen0 + 1, "R5 write enable before erase", m_wen_frames - wen0, 1);
        chk(m_polls - polls0 == k + 1, "R6 status polls after erase", m_polls - polls0, k + 1);
        chk(m_last_addr == 24'(addr), "R1 erase address", int'(m_last_addr), addr);
        chk(nr == 0 && nw == 0, "R4 erase moves no data", nr + nw, 0);
        for (int i = 0; i < 4096; i++) ref_mem[i] = 8'hFF;
    endtask

    task automatic do_reject(input int op, input int len, input string tag);
        bit e, p; int nr, nw, falls0;
        falls0 = m_cs_falls;
        run_req(op, 24'h123456, len, 0, e, nr, nw, p);
        chk(e, {tag, " refused with err"}, int'(e), 1);
        chk(m_cs_falls == falls0, {tag, " no frame driven"}, m_cs_falls - falls0, 0);
    endtask

    initial begin
        bit e, p; int nr, nw, op, a, l;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 4096; i++) ref_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        chk(sf_cs_n === 1'b1, "R3 reset chip select high", int'(sf_cs_n), 1);
        chk(sf_sck === 1'b0, "R2 reset clock low", int'(sf_sck), 0);
        chk(done === 1'b0 && err === 1'b0, "R9 reset done/err low", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 ready after reset", int'(req_ready), 1);

        // R11 status read on an idle device
        run_req(3, 0, 0, 0, e, nr, nw, p);
        chk(!e && nr == 1, "R11 status byte count", nr, 1);
        chk(rbuf[0] == 8'h00, "R11 idle status value", int'(rbuf[0]), 0);
        chk(m_last_opc == 8'h05, "R4 status opcode", int'(m_last_opc), 5);

        do_erase(24'h3A5000, 2);
        do_read(24'h7C1F00, 16);
        do_prog(24'h000100, 256, 3);
        do_read(24'h000100, 256);
        do_prog(24'hC3B2A1, 1, 0);
        do_reject(1, 257, "R7 program of 257");
        do_reject(0, 0, "R7 read of 0");
        do_reject(1, 0, "R7 program of 0");

        for (int it = 0; it < 24 && !hung; it++) begin
            op = $urandom % 5;
            a  = int'($urandom & 32'h00FF_FFFF);
            l  = 1 + ($urandom % 48);
            case (op)
                0, 1: do_read(a, l);
                2, 3: do_prog(a, l, $urandom % 4);
                default: begin
                    run_req(3, a, 0, 0, e, nr, nw, p);
                    chk(nr == 1 && rbuf[0] == 8'h00, "R11 status after idle", int'(rbuf[0]), 0);
                end
            endcase
        end

        chk(!hung, "R9 request completed before watchdog", int'(hung), 0);
        chk(m_proto == 0, "R5 R6 protocol violations", m_proto, 0);
        chk(m_misalign == 0, "R3 partial-byte chip select release", m_misalign, 0);
        chk(m_gap_bad == 0, "R8 short chip select gaps", m_gap_bad, 0);
        chk(m_sck_bad == 0, "R2 clock width or idle errors", m_sck_bad, 0);
        chk(m_mosi_bad == 0, "R2 data moved while clock high", m_mosi_bad, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R9 watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule